// File: doc/BRIEF.md
# Shared Prescaler Tick-Enable Generator

This block turns one input clock into five independent count-enable strobes for a five-channel timer. Two 8-bit prescale values are shared between the channels. The first two channels draw on the low prescaler. The remaining three draw on the high one. Each channel then divides further by its own power of two, chosen with a 4-bit code. The result on every channel is a one-cycle-wide enable that a down-counter can use in place of a slower clock.

Configuration arrives as two words from a register interface, each with its own write strobe: a prescale word and a divider-code word. Writing either word restarts every prescale and divide counter together. All five channels therefore switch to the new rates on the same edge, and each channel's first strobe comes a fixed, predictable number of cycles after the write.

Top module: `tick_enable_gen`

## Requirements
- R1: While reset is asserted every strobe is low. Reset loads prescale values of 1 and divider codes of 0, so after reset release each channel strobes every 2 cycles, first on the second rising edge.
- R2: The prescale word holds the low prescaler in bits [7:0] and the high prescaler in bits [15:8].
- R3: Channels 0 and 1 use the low prescaler. Channels 2, 3 and 4 use the high prescaler. Two channels that share a prescaler and have the same effective code strobe in the same cycles.
- R4: Channel n takes its divider code k from bits [4n+3:4n] of the divider word, and divides by 2^k.
- R5: A divider code above 4 behaves exactly like code 4 (divide by 16).
- R6: Between writes, a channel with prescale value P and divide ratio D strobes once every (P+1)*D cycles.
- R7: When the period is longer than one cycle, each strobe is high for exactly one cycle.
- R8: A write to either word, or to both in the same cycle, restarts all counters. Every strobe is low in the cycle after the write edge, and each channel's first new strobe appears exactly (P+1)*D cycles after that edge, using the newly written values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pscl_we | input | 1 | Write strobe for the prescale word |
| pscl_wdata | input | 16 | Prescale word: low prescaler [7:0], high prescaler [15:8] |
| div_we | input | 1 | Write strobe for the divider-code word |
| div_wdata | input | 20 | Divider word: 4-bit code per channel |
| tick_en | output | 5 | One count-enable strobe per channel |

## Verification
The bound checker tracks the following on every cycle:
- strobes are quiet on the cycle after any write;
- strobes are clean at reset release;
- each strobe is one cycle wide;
- channels with the same prescaler and equal clamped codes stay aligned;
- the gap between consecutive strobes equals (P+1)*D, using a cycle counter that it restarts on writes.

Some properties can only be shown by the bench's scenarios, because they depend on how specific words are decoded. These are:
- the exact latency from a write to the first strobe;
- which word bits feed which channel;
- the clamp of codes above 4;
- the default rates after reset.

// File: rtl/tick_gen_pkg.sv
package tick_gen_pkg;
    localparam int NUM_CH      = 5;  // strobe channels
    localparam int PRE_W       = 8;  // bits per prescale value
    localparam int NUM_PRE     = 2;  // shared prescalers
    localparam int CODE_W      = 4;  // bits per divider code
    localparam int MAX_CODE    = 4;  // largest honoured code (divide by 2^MAX_CODE)
    localparam int GROUP_SPLIT = 2;  // channels below this use prescaler 0

    // Prescaler index that feeds a channel
    function automatic int group_of(input int ch, input int split, input int npre);
        return (ch < split) ? 0 : npre - 1;
    endfunction
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic [W-1:0] limit,
    output logic         pre_tick
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic       wrap;

    always_comb begin
        st_d     = st_q;
        wrap     = (st_q.cnt == limit);
        pre_tick = wrap & ~restart;
        if (restart || wrap) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/tick_divider.sv
module tick_divider #(
    parameter int CODE_W   = 4,
    parameter int MAX_CODE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              pre_tick,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);
    localparam int DW = (MAX_CODE > 0) ? MAX_CODE : 1;

    typedef struct packed {
        logic [DW-1:0] cnt;
        logic          tick;
    } div_state_t;

    div_state_t        st_d, st_q;
    logic [CODE_W-1:0] code_c;
    logic [DW:0]       ratio;
    logic [DW-1:0]     last;

    always_comb begin
        // Clamp oversize codes to the largest ratio
        code_c = (code > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : code;
        ratio  = (DW+1)'(1) << code_c;
        last   = DW'(ratio - 1'b1);

        st_d      = st_q;
        st_d.tick = 1'b0;
        if (restart) begin
            st_d.cnt = '0;
        end else if (pre_tick) begin
            if (st_q.cnt == last) begin
                st_d.cnt  = '0;
                st_d.tick = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick = st_q.tick;
endmodule

// File: rtl/tick_enable_gen.sv
module tick_enable_gen
    import tick_gen_pkg::*;
#(
    parameter int NUM_CH_P      = NUM_CH,
    parameter int PRE_W_P       = PRE_W,
    parameter int NUM_PRE_P     = NUM_PRE,
    parameter int CODE_W_P      = CODE_W,
    parameter int MAX_CODE_P    = MAX_CODE,
    parameter int GROUP_SPLIT_P = GROUP_SPLIT
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          pscl_we,
    input  logic [NUM_PRE_P*PRE_W_P-1:0]  pscl_wdata,
    input  logic                          div_we,
    input  logic [NUM_CH_P*CODE_W_P-1:0]  div_wdata,
    output logic [NUM_CH_P-1:0]           tick_en
);
    localparam int PSCL_W = NUM_PRE_P * PRE_W_P;
    localparam int DIV_W  = NUM_CH_P * CODE_W_P;
    localparam logic [PSCL_W-1:0] PSCL_RST = {NUM_PRE_P{{(PRE_W_P-1){1'b0}}, 1'b1}};

    typedef struct packed {
        logic [PSCL_W-1:0] pscl;
        logic [DIV_W-1:0]  div;
    } cfg_t;

    cfg_t                 cfg_d, cfg_q;
    logic                 restart;
    logic [NUM_PRE_P-1:0] pre_tick;

    always_comb begin
        cfg_d   = cfg_q;
        restart = pscl_we | div_we;
        if (pscl_we) cfg_d.pscl = pscl_wdata;
        if (div_we)  cfg_d.div  = div_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{pscl: PSCL_RST, div: '0};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    for (genvar g = 0; g < NUM_PRE_P; g++) begin : g_pre
        tick_prescaler #(.W(PRE_W_P)) u_pre (
            .clk      (clk),
            .rst_n    (rst_n),
            .restart  (restart),
            .limit    (cfg_q.pscl[g*PRE_W_P +: PRE_W_P]),
            .pre_tick (pre_tick[g])
        );
    end

    for (genvar n = 0; n < NUM_CH_P; n++) begin : g_ch
        localparam int GRP = group_of(n, GROUP_SPLIT_P, NUM_PRE_P);
        tick_divider #(.CODE_W(CODE_W_P), .MAX_CODE(MAX_CODE_P)) u_div (
            .clk      (clk),
            .rst_n    (rst_n),
            .restart  (restart),
            .pre_tick (pre_tick[GRP]),
            .code     (cfg_q.div[n*CODE_W_P +: CODE_W_P]),
            .tick     (tick_en[n])
        );
    end
endmodule

// File: rtl/tick_enable_gen_chk.sv
module tick_enable_gen_chk #(
    parameter int NUM_CH_P      = 5,
    parameter int PRE_W_P       = 8,
    parameter int NUM_PRE_P     = 2,
    parameter int CODE_W_P      = 4,
    parameter int MAX_CODE_P    = 4,
    parameter int GROUP_SPLIT_P = 2
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         pscl_we,
    input logic [NUM_PRE_P*PRE_W_P-1:0] pscl_wdata,
    input logic                         div_we,
    input logic [NUM_CH_P*CODE_W_P-1:0] div_wdata,
    input logic [NUM_CH_P-1:0]          tick_en
);
    localparam int PSCL_W = NUM_PRE_P * PRE_W_P;
    localparam int DIV_W  = NUM_CH_P * CODE_W_P;
    localparam int GW     = PRE_W_P + MAX_CODE_P + 2;

    logic [PSCL_W-1:0] sh_pscl;
    logic [DIV_W-1:0]  sh_div;
    logic              wr;
    assign wr = pscl_we | div_we;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_pscl <= {NUM_PRE_P{{(PRE_W_P-1){1'b0}}, 1'b1}};
            sh_div  <= '0;
        end else begin
            if (pscl_we) sh_pscl <= pscl_wdata;
            if (div_we)  sh_div  <= div_wdata;
        end
    end

    // Effective code after the clamp
    function automatic int eff_code(input int ch, input logic [DIV_W-1:0] d);
        int k;
        k = int'(d[ch*CODE_W_P +: CODE_W_P]);
        return (k > MAX_CODE_P) ? MAX_CODE_P : k;
    endfunction

    function automatic int grp(input int ch);
        return (ch < GROUP_SPLIT_P) ? 0 : NUM_PRE_P - 1;
    endfunction

    function automatic int period(input int ch, input logic [PSCL_W-1:0] p,
                                  input logic [DIV_W-1:0] d);
        return (int'(p[grp(ch)*PRE_W_P +: PRE_W_P]) + 1) << eff_code(ch, d);
    endfunction

    assert_quiet_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (tick_en == '0));

    assert_clean_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (tick_en == '0));

    for (genvar n = 0; n < NUM_CH_P; n++) begin : g_chk
        logic [GW-1:0] gap;
        logic          seen;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                gap  <= '0;
                seen <= 1'b0;
            end else if (wr) begin
                gap  <= '0;
                seen <= 1'b0;
            end else if (tick_en[n]) begin
                gap  <= '0;
                seen <= 1'b1;
            end else begin
                gap  <= gap + 1'b1;
            end
        end

        assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (tick_en[n] && !wr && period(n, sh_pscl, sh_div) > 1) |=> !tick_en[n]);

        assert_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (tick_en[n] && seen && !wr) |-> (int'(gap) + 1 == period(n, sh_pscl, sh_div)));

        if (n != 0 && n != GROUP_SPLIT_P) begin : g_align
            localparam int REF = (n < GROUP_SPLIT_P) ? 0 : GROUP_SPLIT_P;
            assert_group_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (eff_code(n, sh_div) == eff_code(REF, sh_div)) |-> (tick_en[n] == tick_en[REF]));
        end
    end
endmodule

bind tick_enable_gen tick_enable_gen_chk #(
    .NUM_CH_P      (NUM_CH_P),
    .PRE_W_P       (PRE_W_P),
    .NUM_PRE_P     (NUM_PRE_P),
    .CODE_W_P      (CODE_W_P),
    .MAX_CODE_P    (MAX_CODE_P),
    .GROUP_SPLIT_P (GROUP_SPLIT_P)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pscl_we    (pscl_we),
    .pscl_wdata (pscl_wdata),
    .div_we     (div_we),
    .div_wdata  (div_wdata),
    .tick_en    (tick_en)
);

// File: tb/sim_tick_enable_gen.sv
module sim_tick_enable_gen;
    localparam int NCH   = 5;
    localparam int NVEC  = 5;
    // each entry: {prescale word[15:0], divider word[19:0]}
    localparam logic [35:0] VECS [NVEC] = '{
        {16'h0302, 20'h43210},
        {16'h0000, 20'h11111},
        {16'h0507, 20'h9F0C2},
        {16'h0A01, 20'h00021},
        {16'h1300, 20'h32104}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pscl_we = 1'b0;
    logic [15:0] pscl_wdata = '0;
    logic        div_we = 1'b0;
    logic [19:0] div_wdata = '0;
    logic [4:0]  tick_en;

    int checks = 0;
    int errors = 0;
    logic [15:0] cur_pw = 16'h0101;
    logic [19:0] cur_dw = 20'h0;

    always #5 clk = ~clk;

    tick_enable_gen u0 (
        .clk(clk), .rst_n(rst_n),
        .pscl_we(pscl_we), .pscl_wdata(pscl_wdata),
        .div_we(div_we), .div_wdata(div_wdata),
        .tick_en(tick_en)
    );

    function automatic int exp_period(input logic [15:0] pw, input logic [19:0] dw, input int ch);
        int p, k;
        p = (ch < 2) ? int'(pw[7:0]) : int'(pw[15:8]);
        k = int'(dw[ch*4 +: 4]);
        if (k > 4) k = 4;
        return (p + 1) << k;
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Called right after the negedge that follows the restart edge (t=0)
    task automatic measure(input string req);
        int first[NCH];
        int second[NCH];
        int dbl[NCH];
        int per[NCH];
        logic [4:0] prev;
        int win;
        win = 0;
        for (int c = 0; c < NCH; c++) begin
            first[c] = -1; second[c] = -1; dbl[c] = 0;
            per[c] = exp_period(cur_pw, cur_dw, c);
            if (per[c] > win) win = per[c];
        end
        chk(tick_en == 5'b0, "R8", "strobes after restart", int'(tick_en), 0);
        prev = tick_en;
        for (int t = 1; t <= 2 * win + 4; t++) begin
            @(negedge clk);
            for (int c = 0; c < NCH; c++) begin
                if (tick_en[c]) begin
                    if (first[c] < 0) first[c] = t;
                    else if (second[c] < 0) second[c] = t;
                    if (prev[c] && per[c] > 1) dbl[c]++;
                end
            end
            prev = tick_en;
        end
        for (int c = 0; c < NCH; c++) begin
            chk(first[c] == per[c], "R8", $sformatf("%s ch%0d first strobe", req, c), first[c], per[c]);
            chk(second[c] - first[c] == per[c], req, $sformatf("ch%0d period", c), second[c] - first[c], per[c]);
            chk(dbl[c] == 0, "R7", $sformatf("ch%0d wide strobe", c), dbl[c], 0);
        end
    endtask

    task automatic wr_cfg(input bit wp, input logic [15:0] pw, input bit wd, input logic [19:0] dw);
        @(negedge clk);
        pscl_we = wp; pscl_wdata = pw;
        div_we = wd; div_wdata = dw;
        if (wp) cur_pw = pw;
        if (wd) cur_dw = dw;
        @(negedge clk);
        pscl_we = 1'b0; div_we = 1'b0;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog run did not finish actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state and default rates
        repeat (3) @(negedge clk);
        chk(tick_en == 5'b0, "R1", "strobes in reset", int'(tick_en), 0);
        rst_n = 1'b1;
        measure("R1");

        // Table walk: each write lands mid-run and restarts everything
        for (int v = 0; v < NVEC; v++) begin
            wr_cfg(1'b1, VECS[v][35:20], 1'b1, VECS[v][19:0]);
            measure("R6");
        end

        // R2: prescale field positions
        wr_cfg(1'b1, 16'h0104, 1'b1, 20'h00000);
        measure("R2");

        // R3: grouping of channels onto prescalers
        wr_cfg(1'b1, 16'h0600, 1'b0, 20'h0);
        measure("R3");

        // R4: divider field positions, written alone
        wr_cfg(1'b0, 16'h0, 1'b1, 20'h01234);
        measure("R4");

        // R5: clamp at the boundary and beyond
        wr_cfg(1'b1, 16'h0000, 1'b1, 20'hF6545);
        measure("R5");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule